// File: doc/BRIEF.md
# Ninth-Bit Framed Serial Receiver

This receiver sits on the host side of an asynchronous serial link from a modem device that delivers HDLC frames one character at a time. Every character carries a flag beside its eight data bits. Depending on a build parameter, the flag is either a ninth bit inside the serial character or the level of a separate end-of-frame pin. A low flag marks a frame byte. A high flag marks the result word that closes the frame.

The last two frame bytes before each result word are the frame's CRC. The block holds back the two most recent frame bytes and a third byte whose position in the frame is not yet known. A byte is released to the valid/ready payload stream only once it is certain not to be CRC. When the result word arrives, the held CRC pair is dropped and the final payload byte goes out with a last marker. The result word appears on its own output with a one-cycle strobe.

The line is oversampled and each bit is decided by a majority vote. A stop bit read as 0 discards the frame in progress, and the receiver resynchronises on the next result word. Stray bytes after a fast link start are tolerated. For a settling interval after reset, the line is ignored completely.

Top module: `ninebit_frame_rx`

## Requirements
- R1: While reset is asserted, pl_valid, pl_last, rw_valid, short_err and frame_err are all 0.
- R2: For the first SETTLE_CYC clock cycles after reset, no character is received. A character sent in that window produces no output of any kind.
- R3: A character is a start bit (0), the data bits LSB first, the flag bit when FLAG_FROM_PIN is 0, and a stop bit (1), at OVS ticks per bit. Each bit takes the majority of the samples at ticks OVS/2-1, OVS/2 and OVS/2+1 after the falling edge. A start bit that votes 1 is treated as noise and ignored.
- R4: With FLAG_FROM_PIN = 1 the character has no flag bit, and the flag is the level of eof_flag_in at the stop-bit decision.
- R5: A character with flag 1 is a result word. Its data appears on rw_data with rw_valid high for exactly one cycle.
- R6: The two flag-0 bytes received last before a result word never appear on the payload stream.
- R7: For a frame of N >= 3 flag-0 bytes, the first N-2 bytes appear on the payload stream in arrival order. pl_last is 1 on the final byte only.
- R8: A result word closing a frame of fewer than 2 bytes raises short_err together with rw_valid and releases no payload. A frame of exactly 2 bytes releases no payload and raises no error.
- R9: A stop bit read as 0 pulses frame_err and discards the frame. Later flag-0 bytes are ignored until the next result word, which is absorbed with no rw_valid. Assembly then resumes normally.
- R10: While pl_valid is high and pl_ready is low, pl_data holds its value until the next character completes. The consumer accepts within one character time.
- R11: Stray bytes before the first proper frame are closed as an ordinary frame by the next result word. The frame after that is delivered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial receive line, idle high |
| eof_flag_in | input | 1 | End-of-frame flag pin (used when FLAG_FROM_PIN = 1) |
| pl_data | output | DW | Payload byte |
| pl_valid | output | 1 | Payload byte valid |
| pl_ready | input | 1 | Consumer accepts payload |
| pl_last | output | 1 | Payload byte is the last of its frame |
| rw_data | output | DW | Result word |
| rw_valid | output | 1 | One-cycle result word strobe |
| short_err | output | 1 | Result word closed a frame shorter than the CRC |
| frame_err | output | 1 | One-cycle strobe on a stop bit read as 0 |

## Verification
The hardest state to reach is the hunting state after a bad stop bit. The stimulus forces it by driving a 0 in the stop position in the middle of a frame, then sends more data bytes and a result word. The bench expects no payload, no result strobe and one error pulse. The following frame must then come out intact. Single-clock glitches are placed near the centre of data bits so that the majority vote must cover them. A brief low pulse on an idle line tests start-bit rejection. Two instances share the stimulus so that both flag sources see identical frames.

// File: rtl/ninebit_frame_rx.sv
module ninebit_frame_rx #(
  parameter int DW            = 8,
  parameter int OVS           = 16,
  parameter int TICK_DIV      = 1,
  parameter int SETTLE_CYC    = 250000,
  parameter int FLAG_FROM_PIN = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          eof_flag_in,
  output logic [DW-1:0] pl_data,
  output logic          pl_valid,
  input  logic          pl_ready,
  output logic          pl_last,
  output logic [DW-1:0] rw_data,
  output logic          rw_valid,
  output logic          short_err,
  output logic          frame_err
);
  localparam int NBITS = DW + 3 - FLAG_FROM_PIN;
  localparam int SW    = $clog2(OVS);
  localparam int BW    = $clog2(NBITS);
  localparam int TW    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int STW   = $clog2(SETTLE_CYC + 2);
  localparam int MID   = OVS / 2;

  logic [1:0] rx_sync, eof_sync;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sync  <= 2'b11;
      eof_sync <= 2'b00;
    end else begin
      rx_sync  <= {rx_sync[0], rx_line};
      eof_sync <= {eof_sync[0], eof_flag_in};
    end
  wire rxs = rx_sync[1];

  logic [STW-1:0] settle_q;
  wire settled = (settle_q == STW'(SETTLE_CYC));
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        settle_q <= '0;
    else if (!settled) settle_q <= settle_q + 1'b1;

  logic [TW-1:0] div_q;
  wire tick = (div_q == TW'(TICK_DIV - 1));
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;

  logic          busy_q, chr_stb_q, ferr_q, pin_flag_q;
  logic [SW-1:0] smp_q;
  logic [BW-1:0] bit_q;
  logic [1:0]    votes_q;
  logic [DW:0]   sh_q;

  wire [1:0] vote_now = votes_q + {1'b0, rxs};
  wire       bitv     = vote_now[1];
  wire       decide   = busy_q && tick && (smp_q == SW'(MID + 1));
  wire       at_stop  = (bit_q == BW'(NBITS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0; smp_q <= '0; bit_q <= '0; votes_q <= '0; sh_q <= '0;
      chr_stb_q <= 1'b0; ferr_q <= 1'b0; pin_flag_q <= 1'b0;
    end else begin
      chr_stb_q <= 1'b0;
      ferr_q    <= 1'b0;
      if (tick) begin
        if (!busy_q) begin
          if (settled && !rxs) begin
            busy_q <= 1'b1; smp_q <= '0; bit_q <= '0; votes_q <= '0;
          end
        end else begin
          smp_q <= (smp_q == SW'(OVS - 1)) ? '0 : smp_q + 1'b1;
          if (smp_q == SW'(OVS - 1)) bit_q <= bit_q + 1'b1;
          if (smp_q >= SW'(MID - 1) && smp_q <= SW'(MID)) votes_q <= vote_now;
          if (decide) begin
            votes_q <= '0;
            if (bit_q == '0) begin
              if (bitv) busy_q <= 1'b0;
            end else if (at_stop) begin
              busy_q     <= 1'b0;
              chr_stb_q  <= bitv;
              ferr_q     <= !bitv;
              pin_flag_q <= eof_sync[1];
            end else begin
              sh_q <= {bitv, sh_q[DW:1]};
            end
          end
        end
      end
    end

  wire [DW-1:0] chr_data = (FLAG_FROM_PIN != 0) ? sh_q[DW:1] : sh_q[DW-1:0];
  wire          chr_flag = (FLAG_FROM_PIN != 0) ? pin_flag_q : sh_q[DW];

  logic [DW-1:0] hold_q [3];
  logic [1:0]    cnt_q;
  logic          hunt_q;
  wire emit = chr_stb_q && !hunt_q && (cnt_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_q <= '{default: '0};
      cnt_q <= '0; hunt_q <= 1'b0;
      pl_data <= '0; pl_valid <= 1'b0; pl_last <= 1'b0;
      rw_data <= '0; rw_valid <= 1'b0; short_err <= 1'b0; frame_err <= 1'b0;
    end else begin
      rw_valid  <= 1'b0;
      short_err <= 1'b0;
      frame_err <= ferr_q;
      if (ferr_q) begin
        cnt_q  <= '0;
        hunt_q <= 1'b1;
      end else if (chr_stb_q && chr_flag) begin
        cnt_q  <= '0;
        hunt_q <= 1'b0;
        if (!hunt_q) begin
          rw_valid  <= 1'b1;
          rw_data   <= chr_data;
          short_err <= (cnt_q < 2'd2);
        end
      end else if (chr_stb_q && !hunt_q) begin
        hold_q[0] <= chr_data;
        hold_q[1] <= hold_q[0];
        hold_q[2] <= hold_q[1];
        if (cnt_q != 2'd3) cnt_q <= cnt_q + 1'b1;
      end
      if (emit) begin
        pl_valid <= 1'b1;
        pl_data  <= hold_q[2];
        pl_last  <= chr_flag;
      end else if (pl_ready) begin
        pl_valid <= 1'b0;
        pl_last  <= 1'b0;
      end
    end
endmodule

// File: rtl/ninebit_frame_rx_chk.sv
module ninebit_frame_rx_chk #(
  parameter int DW         = 8,
  parameter int SETTLE_CYC = 250000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] pl_data,
  input logic          pl_valid,
  input logic          pl_ready,
  input logic          pl_last,
  input logic          rw_valid,
  input logic          short_err,
  input logic          frame_err,
  input logic          chr_stb_q,
  input logic          chr_flag
);
  localparam int STW = $clog2(SETTLE_CYC + 2);
  logic [STW-1:0] age_q;
  logic           hunt_sh;
  wire warm = (age_q == STW'(SETTLE_CYC));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      age_q   <= '0;
      hunt_sh <= 1'b0;
    end else begin
      if (!warm) age_q <= age_q + 1'b1;
      if (chr_stb_q && chr_flag) hunt_sh <= 1'b0;
      else if (frame_err)        hunt_sh <= 1'b1;
    end

  // R2
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !warm |-> !(rw_valid || pl_valid || frame_err));
  // R5
  rw_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rw_valid |=> !rw_valid);
  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_last |-> pl_valid);
  // R8
  short_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |-> rw_valid);
  // R9
  hunt_no_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_sh |-> !$rose(pl_valid));
  // R10
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && !pl_ready && !chr_stb_q) |=> (pl_valid && $stable(pl_data)));
endmodule

bind ninebit_frame_rx ninebit_frame_rx_chk #(.DW(DW), .SETTLE_CYC(SETTLE_CYC)) i_chk (
  .clk(clk), .rst_n(rst_n), .pl_data(pl_data), .pl_valid(pl_valid),
  .pl_ready(pl_ready), .pl_last(pl_last), .rw_valid(rw_valid),
  .short_err(short_err), .frame_err(frame_err),
  .chr_stb_q(chr_stb_q), .chr_flag(chr_flag)
);

// File: tb/test_ninebit_frame_rx.sv
`timescale 1ns/1ps
module test_ninebit_frame_rx;
  logic clk = 0, rst_n = 0, line_a = 1, line_b = 1, eof_b = 0, rdy = 1;
  logic [7:0] pd_a, rd_a, pd_b, rd_b;
  logic pv_a, pl_a, rv_a, se_a, fe_a, pv_b, pl_b, rv_b, se_b, fe_b;
  always #2 clk = ~clk;

  ninebit_frame_rx #(.SETTLE_CYC(400), .FLAG_FROM_PIN(0)) i_ninebit_frame_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(line_a), .eof_flag_in(1'b0),
    .pl_data(pd_a), .pl_valid(pv_a), .pl_ready(rdy), .pl_last(pl_a),
    .rw_data(rd_a), .rw_valid(rv_a), .short_err(se_a), .frame_err(fe_a));
  ninebit_frame_rx #(.SETTLE_CYC(400), .FLAG_FROM_PIN(1)) i_ninebit_frame_rx_pin (
    .clk(clk), .rst_n(rst_n), .rx_line(line_b), .eof_flag_in(eof_b),
    .pl_data(pd_b), .pl_valid(pv_b), .pl_ready(rdy), .pl_last(pl_b),
    .rw_data(rd_b), .rw_valid(rv_b), .short_err(se_b), .frame_err(fe_b));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] gd [2][64];
  bit gl [2][64];
  int gn [2], rn [2], sn [2], fn [2];
  logic [7:0] rval [2];
  logic [7:0] fr [16];
  logic [7:0] rb;

  always @(negedge clk) begin
    rdy = ($urandom % 4) != 0;
    if (pv_a && rdy && gn[0] < 64) begin gd[0][gn[0]] = pd_a; gl[0][gn[0]] = pl_a; gn[0]++; end
    if (pv_b && rdy && gn[1] < 64) begin gd[1][gn[1]] = pd_b; gl[1][gn[1]] = pl_b; gn[1]++; end
    if (rv_a) begin rn[0]++; rval[0] = rd_a; end
    if (rv_b) begin rn[1]++; rval[1] = rd_b; end
    if (se_a) sn[0]++;
    if (se_b) sn[1]++;
    if (fe_a) fn[0]++;
    if (fe_b) fn[1]++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin gn[d] = 0; rn[d] = 0; sn[d] = 0; fn[d] = 0; end
  endtask

  task automatic send_char(input logic [7:0] d, input bit f, input bit badstop, input bit glitch);
    for (int b = 0; b < 11; b++) begin
      logic va, vb;
      va = (b == 0) ? 1'b0 : (b <= 8) ? d[b-1] : (b == 9) ? f : !badstop;
      vb = (b == 0) ? 1'b0 : (b <= 8) ? d[b-1] : (b == 9) ? !badstop : 1'b1;
      @(negedge clk); line_a = va; line_b = vb; eof_b = f;
      if (glitch && b >= 1 && b <= 8) begin
        repeat (9) @(negedge clk);
        line_a = !va; line_b = !vb;
        @(negedge clk); line_a = va; line_b = vb;
        repeat (5) @(negedge clk);
      end else repeat (15) @(negedge clk);
    end
    @(negedge clk); line_a = 1; line_b = 1; eof_b = 0;
    repeat (15) @(negedge clk);
  endtask

  task automatic check_frame(input int n);
    int en;
    en = (n >= 3) ? n - 2 : 0;
    for (int d = 0; d < 2; d++) begin
      string p;
      p = (d == 1) ? "R4 pin " : "";
      chk(gn[d] == en, {p, "R6 payload count"}, gn[d], en);
      for (int i = 0; i < en && i < gn[d]; i++) begin
        chk(gd[d][i] == fr[i], {p, "R7 payload byte"}, gd[d][i], fr[i]);
        chk(gl[d][i] == (i == en - 1), {p, "R7 last marker"}, gl[d][i], i == en - 1);
      end
      chk(rn[d] == 1, {p, "R5 result strobe count"}, rn[d], 1);
      chk(rval[d] == rb, {p, "R5 result word"}, rval[d], rb);
      chk(sn[d] == (n < 2), {p, "R8 short error"}, sn[d], n < 2);
    end
  endtask

  task automatic send_frame(input int n, input bit glitch);
    clr();
    for (int i = 0; i < n; i++) send_char(fr[i], 0, 0, glitch);
    send_char(rb, 1, 0, glitch);
    repeat (40) @(posedge clk);
    check_frame(n);
  endtask

  task automatic rand_frame(input int n);
    for (int i = 0; i < n; i++) fr[i] = 8'($urandom);
    rb = 8'($urandom);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    // R1
    chk(!pv_a && !pl_a && !rv_a && !se_a && !fe_a, "R1 reset outputs", pv_a | rv_a | fe_a, 0);
    chk(!pv_b && !pl_b && !rv_b && !se_b && !fe_b, "R1 reset outputs pin", pv_b | rv_b | fe_b, 0);
    @(negedge clk); rst_n = 1;
    // R2: a result word sent inside the settling window is ignored
    clr();
    send_char(8'hFF, 1, 0, 0);
    repeat (20) @(posedge clk);
    for (int d = 0; d < 2; d++)
      chk(rn[d] == 0 && gn[d] == 0 && fn[d] == 0, "R2 ignored while settling", rn[d], 0);
    repeat (300) @(posedge clk);

    // R11: stray byte then result word, then a proper frame
    clr();
    send_char(8'h3C, 0, 0, 0);
    send_char(8'hA5, 1, 0, 0);
    repeat (40) @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      chk(sn[d] == 1, "R11 stray bytes closed short", sn[d], 1);
      chk(gn[d] == 0, "R11 no stray payload", gn[d], 0);
    end
    rand_frame(5); send_frame(5, 0);

    // R8 boundary sizes
    for (int n = 0; n < 4; n++) begin rand_frame(n); send_frame(n, 0); end

    // R3 majority vote against glitches
    rand_frame(6); send_frame(6, 1);

    // R3 false start pulse on an idle line
    clr();
    @(negedge clk); line_a = 0; line_b = 0;
    repeat (3) @(negedge clk); line_a = 1; line_b = 1;
    repeat (200) @(posedge clk);
    for (int d = 0; d < 2; d++)
      chk(gn[d] == 0 && rn[d] == 0 && fn[d] == 0, "R3 false start ignored", rn[d] + fn[d], 0);
    rand_frame(4); send_frame(4, 0);

    // R9 framing error mid-frame
    clr();
    send_char(8'h11, 0, 0, 0);
    send_char(8'h22, 0, 0, 0);
    send_char(8'h33, 0, 1, 0);
    send_char(8'h44, 0, 0, 0);
    send_char(8'h55, 0, 0, 0);
    send_char(8'h66, 0, 0, 0);
    send_char(8'h77, 1, 0, 0);
    repeat (40) @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      chk(fn[d] == 1, "R9 frame error strobe", fn[d], 1);
      chk(gn[d] == 0, "R9 discarded payload", gn[d], 0);
      chk(rn[d] == 0, "R9 result absorbed", rn[d], 0);
    end
    rand_frame(7); send_frame(7, 0);

    // R10 random ready throughout; random frames
    for (int k = 0; k < 20; k++) begin
      int n;
      n = $urandom_range(0, 12);
      rand_frame(n);
      send_frame(n, 1'($urandom));
    end
    finish_run();
  end
endmodule